// File: doc/BRIEF.md
# Wavefront-Scheduled Systolic Matrix Multiplier

This block multiplies a ROWS x DEPTH matrix by a DEPTH x COLS matrix on a grid of multiply-accumulate cells. Each grid row has its own row operand store, which holds one row of the first matrix. Each grid column has its own column operand store, which holds one column of the second matrix. Software-side logic fills these stores through a simple write port while the block is idle.

A pulse on `start` clears every accumulator and runs a fixed schedule. Row operands enter at the left column and column operands enter at the top row. Both then ripple one cell per step, to the right and downward, through per-cell operand registers. At step t the cells whose row plus column is at most t, and that still have operand pairs left, are active. Each step has two phases. In the first, all active cells capture new operands. In the second, the active cells multiply and accumulate, and the edge read pointers needed by the next step advance.

After the last step, the accumulators are copied one per cycle, in row-major order, into a result store. The result store can be read through a combinational port. `done` pulses for one cycle after the final copy.

Top module: `wavefront_mac_array`

## Requirements
- R1: After reset, `done` is 0 and the result store reads 0 at every (row, column).
- R2: Each edge store's read pointer is set to all-ones before the schedule. Its first advance wraps it to address 0. Each cell therefore consumes operands from address 0 upward, in consecutive order.
- R3: With `ld_en` high, `ld_left`=1 writes `ld_data` to row store `ld_sel` at address `ld_addr`. `ld_left`=0 writes column store `ld_sel` at that address.
- R4: After `done`, reading (`rd_row`, `rd_col`) gives the sum over k of row-store[row][k] times column-store[col][k], taken modulo 2^AW, with unsigned operands.
- R5: Within each step, operand capture happens in the cycle before multiply-accumulate. A cell at (r, c) pairs its k-th operands at step r+c+k. No pointer advances after the final step.
- R6: Results are copied to the result store one per cycle, in row-major order. `done` rises in the cycle after the last copy.
- R7: `done` is first seen high exactly 2 + 2*(ROWS+COLS+DEPTH-2) + ROWS*COLS clock edges after the edge that samples `start`.
- R8: `done` is high for exactly one cycle.
- R9: Each accepted `start` clears all accumulators, so a run's results do not depend on earlier runs.
- R10: `start` asserted while a run is in progress is ignored. It changes neither the results nor the run length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a run when idle |
| ld_en | input | 1 | Operand store write enable |
| ld_left | input | 1 | 1 selects a row store, 0 a column store |
| ld_sel | input | max(clog2(ROWS),clog2(COLS)) | Store number |
| ld_addr | input | clog2(DEPTH) | Address within the store |
| ld_data | input | DW | Operand value |
| rd_row | input | clog2(ROWS) | Result read row |
| rd_col | input | clog2(COLS) | Result read column |
| rd_data | output | AW | Result at (rd_row, rd_col) |
| done | output | 1 | One-cycle pulse at run end |

## Verification
The hardest condition to reach from the ports is a cell consuming a misaligned operand. This would come from a read pointer off by one, or from a shift that reads a neighbour's already-updated register, and most operand patterns would hide it. To expose it, the stimulus includes matrices with a single nonzero address, where any shift in k zeroes or moves the product. It also includes identity row stores, where every result must reproduce the column matrix exactly. Random matrices and all-maximum operands fill in the rest. A second `start` is injected mid-run to show that it is ignored.

// File: rtl/wma_pkg.sv
package wma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_INIT,
      ST_PRE,
      ST_MOVE,
      ST_FIRE,
      ST_DRAIN
   } wma_state_e;
endpackage

// File: rtl/wma_indexer.sv
module wma_indexer #(
   parameter int unsigned IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          preset,
   input  logic          bump,
   output logic [IW-1:0] idx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      idx <= '0;
      else if (preset) idx <= '1;
      else if (bump)   idx <= idx + IW'(1);
   end
endmodule

// File: rtl/wma_pe.sv
module wma_pe #(
   parameter int unsigned DW = 8,
   parameter int unsigned AW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fire,
   input  logic [DW-1:0] a,
   input  logic [DW-1:0] b,
   output logic [AW-1:0] acc
);
   logic [2*DW-1:0] prod;
   assign prod = {{DW{1'b0}}, a} * {{DW{1'b0}}, b};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    acc <= '0;
      else if (clr)  acc <= '0;
      else if (fire) acc <= acc + AW'(prod);
   end
endmodule

// File: rtl/wma_ctrl.sv
module wma_ctrl
   import wma_pkg::*;
#(
   parameter int unsigned NSTEP = 10,
   parameter int unsigned NOUT  = 16,
   localparam int unsigned SW   = $clog2(NSTEP),
   localparam int unsigned OW   = $clog2(NOUT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   output logic          clr_acc,
   output logic          init_idx,
   output logic          pre_inc,
   output logic          mv_en,
   output logic          fire_en,
   output logic          last_step,
   output logic [SW-1:0] step,
   output logic          drain_en,
   output logic [OW-1:0] drain_ix,
   output logic          done
);
   localparam logic [SW-1:0] STEP_END  = SW'(NSTEP - 1);
   localparam logic [OW-1:0] DRAIN_END = OW'(NOUT - 1);

   wma_state_e state;

   assign clr_acc   = (state == ST_IDLE) && start;
   assign init_idx  = (state == ST_INIT);
   assign pre_inc   = (state == ST_PRE);
   assign mv_en     = (state == ST_MOVE);
   assign fire_en   = (state == ST_FIRE);
   assign drain_en  = (state == ST_DRAIN);
   assign last_step = (step == STEP_END);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         step     <= '0;
         drain_ix <= '0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE:  if (start) state <= ST_INIT;
            ST_INIT:  state <= ST_PRE;
            ST_PRE: begin
               step  <= '0;
               state <= ST_MOVE;
            end
            ST_MOVE:  state <= ST_FIRE;
            ST_FIRE: begin
               if (last_step) begin
                  drain_ix <= '0;
                  state    <= ST_DRAIN;
               end else begin
                  step  <= step + SW'(1);
                  state <= ST_MOVE;
               end
            end
            ST_DRAIN: begin
               if (drain_ix == DRAIN_END) begin
                  done  <= 1'b1;
                  state <= ST_IDLE;
               end else begin
                  drain_ix <= drain_ix + OW'(1);
               end
            end
            default:  state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/wavefront_mac_array.sv
module wavefront_mac_array #(
   parameter int unsigned ROWS  = 4,
   parameter int unsigned COLS  = 4,
   parameter int unsigned DEPTH = 4,
   parameter int unsigned DW    = 8,
   parameter int unsigned AW    = 2 * DW + $clog2(DEPTH),
   localparam int unsigned IW   = $clog2(DEPTH),
   localparam int unsigned RW   = $clog2(ROWS),
   localparam int unsigned CW   = $clog2(COLS),
   localparam int unsigned SELW = (RW > CW) ? RW : CW
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            ld_en,
   input  logic            ld_left,
   input  logic [SELW-1:0] ld_sel,
   input  logic [IW-1:0]   ld_addr,
   input  logic [DW-1:0]   ld_data,
   input  logic [RW-1:0]   rd_row,
   input  logic [CW-1:0]   rd_col,
   output logic [AW-1:0]   rd_data,
   output logic            done
);
   localparam int unsigned NSTEP = ROWS + COLS + DEPTH - 2;
   localparam int unsigned SW    = $clog2(NSTEP);
   localparam int unsigned NOUT  = ROWS * COLS;
   localparam int unsigned OW    = $clog2(NOUT);

   if (ROWS < 2 || COLS < 2 || DEPTH < 2) begin : g_bad_size
      $error("wavefront_mac_array: ROWS, COLS and DEPTH must each be at least 2");
   end
   if (AW < 2 * DW) begin : g_bad_acc
      $error("wavefront_mac_array: AW must hold a full product");
   end

   // control
   logic          clr_acc, init_idx, pre_inc, mv_en, fire_en, last_step, drain_en;
   logic [SW-1:0] step;
   logic [OW-1:0] drain_ix;

   wma_ctrl #(.NSTEP(NSTEP), .NOUT(NOUT)) u_ctrl (
      .clk, .rst_n, .start,
      .clr_acc, .init_idx, .pre_inc, .mv_en, .fire_en, .last_step,
      .step, .drain_en, .drain_ix, .done
   );

   // edge operand stores
   logic [DW-1:0] lmem [ROWS][DEPTH];
   logic [DW-1:0] tmem [COLS][DEPTH];

   always_ff @(posedge clk) begin
      if (ld_en) begin
         if (ld_left) lmem[ld_sel[RW-1:0]][ld_addr] <= ld_data;
         else         tmem[ld_sel[CW-1:0]][ld_addr] <= ld_data;
      end
   end

   // edge read pointers
   logic [IW-1:0] lidx [ROWS];
   logic [IW-1:0] tidx [COLS];

   for (genvar r = 0; r < ROWS; r++) begin : g_lptr
      logic nxt, bump;
      assign nxt  = (int'(step) + 1 >= r) && (int'(step) + 1 < r + DEPTH);
      assign bump = (pre_inc && (r == 0)) || (fire_en && !last_step && nxt);
      wma_indexer #(.IW(IW)) u_idx (
         .clk, .rst_n, .preset(init_idx), .bump, .idx(lidx[r])
      );
   end

   for (genvar c = 0; c < COLS; c++) begin : g_tptr
      logic nxt, bump;
      assign nxt  = (int'(step) + 1 >= c) && (int'(step) + 1 < c + DEPTH);
      assign bump = (pre_inc && (c == 0)) || (fire_en && !last_step && nxt);
      wma_indexer #(.IW(IW)) u_idx (
         .clk, .rst_n, .preset(init_idx), .bump, .idx(tidx[c])
      );
   end

   // grid of cells with shifting operand registers
   logic [DW-1:0] lbus [ROWS][COLS-1];
   logic [DW-1:0] tbus [ROWS-1][COLS];
   logic [AW-1:0] acc_flat [NOUT];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         localparam int unsigned DIAG = r + c;
         logic          act;
         logic [DW-1:0] lsrc, tsrc, l_q, t_q;

         assign act = (int'(step) >= DIAG) && (int'(step) < DIAG + DEPTH);

         if (c == 0) begin : g_lin
            assign lsrc = lmem[r][lidx[r]];
         end else begin : g_lsh
            assign lsrc = lbus[r][c-1];
         end
         if (r == 0) begin : g_tin
            assign tsrc = tmem[c][tidx[c]];
         end else begin : g_tsh
            assign tsrc = tbus[r-1][c];
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               l_q <= '0;
               t_q <= '0;
            end else if (mv_en && act) begin
               l_q <= lsrc;
               t_q <= tsrc;
            end
         end

         if (c < COLS - 1) begin : g_lout
            assign lbus[r][c] = l_q;
         end
         if (r < ROWS - 1) begin : g_tout
            assign tbus[r][c] = t_q;
         end

         wma_pe #(.DW(DW), .AW(AW)) u_pe (
            .clk, .rst_n, .clr(clr_acc), .fire(fire_en && act),
            .a(l_q), .b(t_q), .acc(acc_flat[r*COLS + c])
         );
      end
   end

   // result store, filled row-major
   logic [AW-1:0] omem [NOUT];
   logic [OW-1:0] rd_lin;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < NOUT; k++) omem[k] <= '0;
      end else if (drain_en) begin
         omem[drain_ix] <= acc_flat[drain_ix];
      end
   end

   assign rd_lin  = OW'(rd_row * COLS + rd_col);
   assign rd_data = omem[rd_lin];
endmodule

// File: rtl/wma_chk.sv
module wma_chk #(
   parameter int unsigned IW = 2,
   parameter int unsigned OW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          done,
   input logic          pre_inc,
   input logic          mv_en,
   input logic          fire_en,
   input logic          drain_en,
   input logic [IW-1:0] tidx0,
   input logic [IW-1:0] lidx0,
   input logic [OW-1:0] drain_ix
);
   // R2
   idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pre_inc |=> (tidx0 == '0) && (lidx0 == '0));

   // R5
   fire_after_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire_en |-> $past(mv_en));

   // R6
   drain_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (drain_en && $past(drain_en)) |-> (drain_ix == $past(drain_ix) + OW'(1)));

   // R6
   done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(drain_en));

   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind wavefront_mac_array wma_chk #(.IW(IW), .OW(OW)) u_wma_chk (
   .clk(clk), .rst_n(rst_n), .done(done),
   .pre_inc(pre_inc), .mv_en(mv_en), .fire_en(fire_en), .drain_en(drain_en),
   .tidx0(tidx[0]), .lidx0(lidx[0]), .drain_ix(drain_ix)
);

// File: tb/test_wavefront_mac_array.sv
`timescale 1ns/1ps
module test_wavefront_mac_array;
   localparam int R  = 4;
   localparam int C  = 4;
   localparam int D  = 4;
   localparam int DW = 8;
   localparam int AW = 2 * DW + 2;
   localparam int LAT = 2 + 2 * (R + C + D - 2) + R * C;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic ld_en = 1'b0;
   logic ld_left = 1'b0;
   logic [1:0] ld_sel = '0;
   logic [1:0] ld_addr = '0;
   logic [DW-1:0] ld_data = '0;
   logic [1:0] rd_row = '0;
   logic [1:0] rd_col = '0;
   logic [AW-1:0] rd_data;
   logic done;

   int nchk = 0;
   int nfail = 0;
   int unsigned lm [R][D];
   int unsigned tm [D][C];

   always #2 clk = ~clk;

   wavefront_mac_array i_wavefront_mac_array (
      .clk, .rst_n, .start, .ld_en, .ld_left, .ld_sel, .ld_addr, .ld_data,
      .rd_row, .rd_col, .rd_data, .done
   );

   task automatic chk(input string req, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic longint ref_cell(input int r, input int c);
      longint s = 0;
      for (int k = 0; k < D; k++) s += longint'(lm[r][k]) * longint'(tm[k][c]);
      return s & ((longint'(1) << AW) - 1);
   endfunction

   task automatic load_all();
      for (int r = 0; r < R; r++)
         for (int k = 0; k < D; k++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_left = 1'b1; ld_sel = 2'(r); ld_addr = 2'(k);
            ld_data = DW'(lm[r][k]);
         end
      for (int c = 0; c < C; c++)
         for (int k = 0; k < D; k++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_left = 1'b0; ld_sel = 2'(c); ld_addr = 2'(k);
            ld_data = DW'(tm[k][c]);
         end
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   task automatic run_check(input string req, input bit poke);
      int cyc = 0;
      bit seen = 0;
      load_all();
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      while (!seen && cyc < 5000) begin
         @(posedge clk);
         cyc++;
         #1;
         start = 1'b0;
         if (done) seen = 1;
         else if (poke && cyc == 10) start = 1'b1; // R10: ignored mid-run
      end
      chk("R7 latency", cyc, LAT);
      @(posedge clk);
      #1;
      chk("R8 done width", done, 0);
      for (int r = 0; r < R; r++)
         for (int c = 0; c < C; c++) begin
            rd_row = 2'(r);
            rd_col = 2'(c);
            #1;
            chk(req, rd_data, ref_cell(r, c));
         end
   endtask

   initial begin
      #400000;
      nfail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1
      chk("R1 done", done, 0);
      for (int r = 0; r < R; r++)
         for (int c = 0; c < C; c++) begin
            rd_row = 2'(r);
            rd_col = 2'(c);
            #1;
            chk("R1 result", rd_data, 0);
         end

      // R2: only address 0 nonzero
      for (int r = 0; r < R; r++)
         for (int k = 0; k < D; k++) lm[r][k] = (k == 0) ? r + 3 : 0;
      for (int k = 0; k < D; k++)
         for (int c = 0; c < C; c++) tm[k][c] = (k == 0) ? c + 5 : 0;
      run_check("R2 first address", 0);

      // R3 and R5: identity rows reproduce the column matrix
      for (int r = 0; r < R; r++)
         for (int k = 0; k < D; k++) lm[r][k] = (k == r) ? 1 : 0;
      for (int k = 0; k < D; k++)
         for (int c = 0; c < C; c++) tm[k][c] = 16 * k + c + 1;
      run_check("R3/R5 identity", 0);

      // R4: all maximum operands
      for (int r = 0; r < R; r++)
         for (int k = 0; k < D; k++) lm[r][k] = 255;
      for (int k = 0; k < D; k++)
         for (int c = 0; c < C; c++) tm[k][c] = 255;
      run_check("R4 full scale", 0);

      // R9: zeros after a large run must read zero
      for (int r = 0; r < R; r++)
         for (int k = 0; k < D; k++) lm[r][k] = 0;
      run_check("R9 clear", 0);

      // R4/R6 random, R10 with mid-run start
      for (int n = 0; n < 6; n++) begin
         for (int r = 0; r < R; r++)
            for (int k = 0; k < D; k++) lm[r][k] = $urandom_range(255, 0);
         for (int k = 0; k < D; k++)
            for (int c = 0; c < C; c++) tm[k][c] = $urandom_range(255, 0);
         if (n % 2 == 1) run_check("R10 restart ignored", 1);
         else            run_check("R4/R6 random", 0);
      end

      $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end
endmodule